// File: doc/BRIEF.md
# Dual-Mode Converter Control Interface

This block is the mode-control front end of a data converter. A static strap input decides how three control pins behave. With the strap tied low, chip-select, serial clock and serial data form a small register port. A master writes and reads back a bank of mode registers through it. With the strap tied high, the same three pins are plain level inputs, and each one drives one operating mode directly.

In both modes the block presents four decoded controls to the rest of the converter: a half-current select for the output drivers, a sleep request, a clock duty-cycle stabilizer enable and an output clock phase delay. The serial pins are sampled by the system clock `clk`, and serial clock edges are found by comparing successive samples. Read-back data leaves through an open-drain pull-down enable. The pad itself is outside this block.

Top module: `mcif_mode_ctrl`

## Requirements
- R1: With `par_strap` high, `drv_half` follows `sdi`, `sleep_en` follows `sck`, `dcs_en` follows `cs_n` (pin high means stabilizer on), and `clk_phase` is 0, all without a clock delay.
- R2: With `par_strap` high, serial traffic on the pins writes no register and `sdo_pd` stays 0. After the strap returns low, the outputs show the register values held before.
- R3: A serial frame is 16 bits, MSB first, captured on rising `sck` edges while `cs_n` is low: a read/write flag (0 = write), a 7-bit address, then 8 data bits. A write takes effect at the 16th rising edge.
- R4: Register 0 holds `drv_half` in bit 0, `sleep_en` in bit 1 and `dcs_en` in bit 2. Register 1 holds `clk_phase` in bits 1:0. Every other bit of both registers reads back as 0.
- R5: A write to an address other than 0 or 1 changes nothing, and a read of such an address returns 0.
- R6: In a read frame the register value leaves MSB first. Each bit appears after a rising `sck` edge, starting with the 8th, and holds through the falling edge that follows. `sdo_pd` is high exactly when the current bit is 0.
- R7: `sdo_pd` is 0 while `cs_n` is high, during the first seven header bits, and throughout every write frame.
- R8: Raising `cs_n` before the 16th bit abandons the frame without a write. `sck` edges while `cs_n` is high have no effect, and the next frame starts from its first bit.
- R9: Rising `sck` edges after the 16th bit and before `cs_n` rises are ignored.
- R10: `sdi` is sampled only at rising `sck` edges. Changes while `sck` is high have no effect.
- R11: A synchronous reset returns both registers to 0: full current, awake, stabilizer off, zero phase delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples all pins |
| rst | input | 1 | Synchronous active-high reset |
| par_strap | input | 1 | Static strap: 0 serial register port, 1 parallel pin control |
| cs_n | input | 1 | Chip-select (serial) or stabilizer enable (parallel) |
| sck | input | 1 | Serial clock (serial) or sleep request (parallel) |
| sdi | input | 1 | Serial data in (serial) or half-current select (parallel) |
| sdo_pd | output | 1 | Open-drain pull-down enable of the data-out pad |
| drv_half | output | 1 | Output drivers at half current |
| sleep_en | output | 1 | Sleep request |
| dcs_en | output | 1 | Clock duty-cycle stabilizer enable |
| clk_phase | output | 2 | Output clock phase delay code |

## Verification
Two functions can meet in one rising `sck` edge. At the 16th edge of a frame, the register write commits, the read data path releases `sdo_pd`, and the decoded outputs change. The bench provokes this with back-to-back write and read frames to the same register. It checks that the new outputs are visible right after that edge and that the following read returns the value just written. A second overlap arises when the frame is cut short or padded: `cs_n` rises in the cycle where a write would otherwise commit, or extra edges follow the commit. In both cases the outputs are judged against a register model kept in the bench.

// File: rtl/mcif_pkg.sv
package mcif_pkg;

    localparam int ADDR_W     = 7;
    localparam int DATA_W     = 8;
    localparam int PHASE_W    = 2;
    localparam int NUM_REGS   = 2;
    localparam int HDR_BITS   = 1 + ADDR_W;
    localparam int FRAME_BITS = HDR_BITS + DATA_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);

    localparam int REG_CTRL   = 0;
    localparam int REG_PHASE  = 1;
    localparam int BIT_HALF   = 0;
    localparam int BIT_SLEEP  = 1;
    localparam int BIT_DCS    = 2;
    localparam int CTRL_BITS  = 3;

    typedef struct packed {
        logic               drv_half;
        logic               sleep;
        logic               dcs_en;
        logic [PHASE_W-1:0] phase;
    } mode_t;

    typedef enum logic [1:0] {
        ST_HDR  = 2'd0,
        ST_DATA = 2'd1,
        ST_DONE = 2'd2
    } frame_st_e;

    // Writable bits of each register; anything outside reads as zero.
    function automatic logic [DATA_W-1:0] reg_mask(input int idx);
        if (idx == REG_CTRL)
            return DATA_W'((1 << CTRL_BITS) - 1);
        else if (idx == REG_PHASE)
            return DATA_W'((1 << PHASE_W) - 1);
        else
            return '0;
    endfunction

    // Parallel strap: each pin is one mode level.
    function automatic mode_t decode_pins(input logic cs_n_pin,
                                          input logic sck_pin,
                                          input logic sdi_pin);
        mode_t m;
        m.drv_half = sdi_pin;
        m.sleep    = sck_pin;
        m.dcs_en   = cs_n_pin;
        m.phase    = '0;
        return m;
    endfunction

endpackage

// File: rtl/mcif_frame_engine.sv
module mcif_frame_engine
    import mcif_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  logic          cs_n,
    input  logic          sck,
    input  logic          sdi,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          sdo_pd
);

    localparam int HB = 1 + AW;
    localparam int FB = HB + DW;
    localparam int CW = $clog2(FB + 1);
    localparam int SW = FB - 1;

    logic          sck_q;
    logic          rise;
    logic          live;
    frame_st_e     st_q;
    logic [CW-1:0] cnt_q;
    logic [SW-1:0] sh_q;
    logic [DW-1:0] out_q;
    logic          rd_active_q;
    logic          last_bit;
    logic          hdr_last;

    assign live     = enable && !cs_n;
    assign rise     = sck && !sck_q;
    assign hdr_last = (cnt_q == CW'(HB - 1));
    assign last_bit = (cnt_q == CW'(FB - 1));

    // Address as it completes on the last header edge.
    assign rd_addr = {sh_q[AW-2:0], sdi};

    // Write fields as they complete on the last frame edge.
    assign wr_en   = live && rise && (st_q == ST_DATA) && last_bit && !sh_q[SW-1];
    assign wr_addr = sh_q[SW-2 -: AW];
    assign wr_data = {sh_q[DW-2:0], sdi};

    assign sdo_pd  = live && rd_active_q && !out_q[DW-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q       <= 1'b0;
            st_q        <= ST_HDR;
            cnt_q       <= '0;
            sh_q        <= '0;
            out_q       <= '0;
            rd_active_q <= 1'b0;
        end else begin
            sck_q <= sck;
            if (!live) begin
                st_q        <= ST_HDR;
                cnt_q       <= '0;
                rd_active_q <= 1'b0;
            end else if (rise) begin
                case (st_q)
                    ST_HDR: begin
                        sh_q  <= {sh_q[SW-2:0], sdi};
                        cnt_q <= cnt_q + CW'(1);
                        if (hdr_last) begin
                            st_q        <= ST_DATA;
                            out_q       <= rd_data;
                            rd_active_q <= sh_q[AW-1];
                        end
                    end
                    ST_DATA: begin
                        sh_q  <= {sh_q[SW-2:0], sdi};
                        cnt_q <= cnt_q + CW'(1);
                        out_q <= {out_q[DW-2:0], 1'b0};
                        if (last_bit) begin
                            st_q        <= ST_DONE;
                            rd_active_q <= 1'b0;
                        end
                    end
                    default: begin
                        st_q <= ST_DONE;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/mcif_reg_bank.sv
module mcif_reg_bank
    import mcif_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int NR = NUM_REGS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output mode_t         reg_mode
);

    logic [NR-1:0][DW-1:0] bank;

    for (genvar g = 0; g < NR; g++) begin : g_reg
        logic [DW-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (wr_en && wr_addr == AW'(g))
                q <= wr_data & DW'(reg_mask(g));
        end
        assign bank[g] = q;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NR; i++) begin
            if (rd_addr == AW'(i))
                rd_data = bank[i];
        end
    end

    always_comb begin
        reg_mode.drv_half = bank[REG_CTRL][BIT_HALF];
        reg_mode.sleep    = bank[REG_CTRL][BIT_SLEEP];
        reg_mode.dcs_en   = bank[REG_CTRL][BIT_DCS];
        reg_mode.phase    = bank[REG_PHASE][PHASE_W-1:0];
    end

endmodule

// File: rtl/mcif_mode_select.sv
module mcif_mode_select
    import mcif_pkg::*;
(
    input  logic  par_mode,
    input  logic  cs_n,
    input  logic  sck,
    input  logic  sdi,
    input  mode_t reg_mode,
    output mode_t mode
);

    mode_t pin_mode;

    assign pin_mode = decode_pins(cs_n, sck, sdi);
    assign mode     = par_mode ? pin_mode : reg_mode;

endmodule

// File: rtl/mcif_mode_ctrl.sv
module mcif_mode_ctrl
    import mcif_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int NR = NUM_REGS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               par_strap,
    input  logic               cs_n,
    input  logic               sck,
    input  logic               sdi,
    output logic               sdo_pd,
    output logic               drv_half,
    output logic               sleep_en,
    output logic               dcs_en,
    output logic [PHASE_W-1:0] clk_phase
);

    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data;
    mode_t         reg_mode;
    mode_t         mode;

    mcif_frame_engine #(.AW(AW), .DW(DW)) u_engine (
        .clk     (clk),
        .rst     (rst),
        .enable  (!par_strap),
        .cs_n    (cs_n),
        .sck     (sck),
        .sdi     (sdi),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .sdo_pd  (sdo_pd)
    );

    mcif_reg_bank #(.AW(AW), .DW(DW), .NR(NR)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .reg_mode (reg_mode)
    );

    mcif_mode_select u_sel (
        .par_mode (par_strap),
        .cs_n     (cs_n),
        .sck      (sck),
        .sdi      (sdi),
        .reg_mode (reg_mode),
        .mode     (mode)
    );

    assign drv_half  = mode.drv_half;
    assign sleep_en  = mode.sleep;
    assign dcs_en    = mode.dcs_en;
    assign clk_phase = mode.phase;

endmodule

// File: rtl/mcif_mode_ctrl_chk.sv
module mcif_mode_ctrl_chk
    import mcif_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               par_strap,
    input logic               cs_n,
    input logic               sck,
    input logic               sdo_pd,
    input logic               drv_half,
    input logic               sleep_en,
    input logic               dcs_en,
    input logic [PHASE_W-1:0] clk_phase
);

    logic [PHASE_W+2:0] outs;
    assign outs = {dcs_en, sleep_en, drv_half, clk_phase};

    // R11
    reset_default_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !par_strap) |-> (outs == '0));

    // R3
    cfg_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (!par_strap && !$past(par_strap) && !$past(rst) && outs != $past(outs))
        |-> (!$past(cs_n) && $past(sck) && !$past(sck, 2)));

    // R6
    sdo_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (sdo_pd != $past(sdo_pd))
        |-> (($past(sck) && !$past(sck, 2)) || (cs_n != $past(cs_n))
             || $past(cs_n) || (par_strap != $past(par_strap)) || $past(rst)));

    // R7
    sdo_needs_select_chk: assert property (@(posedge clk) disable iff (rst)
        sdo_pd |-> (!$past(cs_n) && !$past(par_strap)));

endmodule

bind mcif_mode_ctrl mcif_mode_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .par_strap (par_strap),
    .cs_n      (cs_n),
    .sck       (sck),
    .sdo_pd    (sdo_pd),
    .drv_half  (drv_half),
    .sleep_en  (sleep_en),
    .dcs_en    (dcs_en),
    .clk_phase (clk_phase)
);

// File: tb/mcif_mode_ctrl_test.sv
module mcif_mode_ctrl_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       par_strap = 1'b0;
    logic       cs_n = 1'b1;
    logic       sck = 1'b0;
    logic       sdi = 1'b0;
    logic       sdo_pd;
    logic       drv_half;
    logic       sleep_en;
    logic       dcs_en;
    logic [1:0] clk_phase;

    int  checks = 0;
    int  fails  = 0;
    bit  finished = 1'b0;

    logic [2:0] m_ctrl  = '0;
    logic [1:0] m_phase = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcif_mode_ctrl uut (
        .clk       (clk),
        .rst       (rst),
        .par_strap (par_strap),
        .cs_n      (cs_n),
        .sck       (sck),
        .sdi       (sdi),
        .sdo_pd    (sdo_pd),
        .drv_half  (drv_half),
        .sleep_en  (sleep_en),
        .dcs_en    (dcs_en),
        .clk_phase (clk_phase)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] outs_now();
        return {dcs_en, sleep_en, drv_half, clk_phase};
    endfunction

    function automatic logic [4:0] outs_model();
        return {m_ctrl[2], m_ctrl[1], m_ctrl[0], m_phase};
    endfunction

    // One serial bit; entered and left at a negedge with sck low.
    task automatic sbit(input logic b, input bit glitch, output logic r, output bit stable);
        sdi = b;
        @(negedge clk) sck = 1'b1;
        @(negedge clk);
        if (glitch) sdi = ~b;
        r = ~sdo_pd;
        sck = 1'b0;
        @(negedge clk);
        stable = ((~sdo_pd) == r);
    endtask

    // Full frame plus optional extra bits; returns read data and flags.
    task automatic xfer(input logic rw, input logic [6:0] a, input logic [7:0] d,
                        input bit glitch, input int extra,
                        output logic [7:0] rd, output bit quiet, output bit stable);
        logic [15:0] fr;
        logic r;
        bit s;
        fr = {rw, a, d};
        rd = '0;
        quiet = 1'b1;
        stable = 1'b1;
        cs_n = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 16; i++) begin
            sbit(fr[15-i], glitch, r, s);
            if (i < 7 || !rw) quiet &= r;
            if (i >= 7 && i <= 14) begin
                rd[14-i] = r;
                stable &= s;
            end
        end
        for (int k = 0; k < extra; k++) begin
            sbit(1'b1, 1'b0, r, s);
            quiet &= r;
        end
        cs_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] rd;
        bit q;
        bit st;
        logic r;
        bit s;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 reset outputs", outs_now(), 5'h00);
        chk("R7 idle release", sdo_pd, 1'b0);

        // R3 R4 R10: sweep all stabilizer/sleep/current combinations.
        for (int v = 0; v < 8; v++) begin
            xfer(1'b0, 7'd0, {5'b10101, v[2:0]}, v[0], 0, rd, q, st);
            m_ctrl = v[2:0];
            chk("R3 R4 R10 ctrl write", outs_now(), outs_model());
            chk("R7 write frame quiet", q, 1'b1);
            xfer(1'b1, 7'd0, 8'h00, 1'b0, 0, rd, q, st);
            chk("R6 R4 ctrl readback", rd, {5'b0, v[2:0]});
            chk("R6 stable over fall", st, 1'b1);
            chk("R7 header quiet", q, 1'b1);
        end

        // R4: phase field sweep.
        for (int p = 0; p < 4; p++) begin
            xfer(1'b0, 7'd1, {6'b111111, p[1:0]}, 1'b0, 0, rd, q, st);
            m_phase = p[1:0];
            chk("R4 phase write", outs_now(), outs_model());
            xfer(1'b1, 7'd1, 8'h00, 1'b0, 0, rd, q, st);
            chk("R4 R6 phase readback", rd, {6'b0, p[1:0]});
        end

        // R5: unmapped addresses.
        for (int k = 0; k < 3; k++) begin
            logic [6:0] ua;
            ua = (k == 0) ? 7'd2 : (k == 1) ? 7'd64 : 7'd127;
            xfer(1'b0, ua, 8'hFF, 1'b0, 0, rd, q, st);
            chk("R5 unmapped write ignored", outs_now(), outs_model());
            xfer(1'b1, ua, 8'h00, 1'b0, 0, rd, q, st);
            chk("R5 unmapped read zero", rd, 8'h00);
        end

        // R8: abort after 15 bits, then sck edges with cs high.
        cs_n = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 15; i++) begin
            logic [15:0] fr;
            fr = {1'b0, 7'd0, 8'h05};
            sbit(fr[15-i], 1'b0, r, s);
        end
        cs_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R8 aborted frame no write", outs_now(), outs_model());
        for (int i = 0; i < 5; i++) sbit(1'b0, 1'b0, r, s);
        chk("R8 deselected edges ignored", outs_now(), outs_model());
        chk("R7 released while deselected", sdo_pd, 1'b0);
        xfer(1'b0, 7'd0, 8'h05, 1'b0, 0, rd, q, st);
        m_ctrl = 3'b101;
        chk("R8 frame after abort", outs_now(), outs_model());

        // R9: trailing bits after a complete write.
        xfer(1'b0, 7'd0, 8'h02, 1'b0, 8, rd, q, st);
        m_ctrl = 3'b010;
        chk("R9 trailing bits ignored", outs_now(), outs_model());
        chk("R7 trailing bits quiet", q, 1'b1);
        xfer(1'b1, 7'd0, 8'h00, 1'b0, 5, rd, q, st);
        chk("R9 read with trailing bits", rd, 8'h02);

        // R11: reset after configuration.
        xfer(1'b0, 7'd1, 8'h03, 1'b0, 0, rd, q, st);
        m_phase = 2'd3;
        chk("R4 phase before reset", outs_now(), outs_model());
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        m_ctrl = '0;
        m_phase = '0;
        chk("R11 reset clears registers", outs_now(), 5'h00);

        // Preload a value so R2 can show it survives parallel mode.
        xfer(1'b0, 7'd0, 8'h06, 1'b0, 0, rd, q, st);
        m_ctrl = 3'b110;
        chk("R3 preload", outs_now(), outs_model());

        // R1: parallel pin decode, every pin combination.
        par_strap = 1'b1;
        for (int v = 0; v < 8; v++) begin
            cs_n = v[2];
            sck  = v[1];
            sdi  = v[0];
            #1;
            chk("R1 parallel decode", outs_now(), {v[2], v[1], v[0], 2'b00});
            chk("R2 parallel release", sdo_pd, 1'b0);
            @(negedge clk);
        end
        cs_n = 1'b1;
        sck  = 1'b0;
        sdi  = 1'b0;
        @(negedge clk);

        // R2: serial traffic in parallel mode.
        xfer(1'b0, 7'd0, 8'h01, 1'b0, 0, rd, q, st);
        xfer(1'b1, 7'd0, 8'h00, 1'b0, 0, rd, q, st);
        chk("R2 no pull-down in parallel", rd, 8'hFF);
        par_strap = 1'b0;
        @(negedge clk);
        chk("R2 registers kept", outs_now(), outs_model());

        finish_run();
    end

endmodule